// File: doc/BRIEF.md
# Indirect SDRAM Controller Configuration Registers

This block is the configuration and status register file of a memory controller. Software on a register bus sees only two port locations. One is an index register that holds a sub-register offset. The other is a data window. Reads and writes of the window go to whichever sub-register the stored index selects. Each sub-register has its own write mask. The file holds the following:
- controller enable and status bits
- two write-1-to-clear bus-error status words
- an error address
- refresh, power-management, timing and ECC configuration words
- an ECC error status word
- four bank configuration words, each giving a bank base, a size code and an enable

From this state the block drives two kinds of output. The first is a one-hot bank-hit vector for a lookup address. The second is a level interrupt that is high while the ECC error status is nonzero. Command sequencing, refresh generation and the data path sit elsewhere.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset the sub-registers read as follows:
  - config reads 0x00800000.
  - refresh reads 0x05F00000.
  - power-management reads 0x07C00000.
  - the index register and every other stored sub-register read 0.
  - `ecc_irq` and `bank_hit` are 0.
- R2: Port offset 0x10 is the index register, which is written and read back whole. Port offset 0x11 is the data window onto the sub-register at the stored index. The window offsets are:
  - 0x00 and 0x08: bus-error status.
  - 0x10: error address.
  - 0x20: config.
  - 0x24: status.
  - 0x30: refresh.
  - 0x34: power-management.
  - 0x40, 0x44, 0x48, 0x4C: banks 0 to 3.
  - 0x80: timing.
  - 0x94: ECC config.
  - 0x98: ECC error status.

  A window read at any other index returns 0xFFFFFFFF. The timing window always reads 0xFFFFFFFF.
- R3: Writing the bus-error status words clears the bits written as 1. No bit is ever set in them.
- R4: The status word ignores writes. It changes only on a config write:
  - Config bit 31 going 0→1 clears status bit 31.
  - Config bit 31 going 1→0 sets status bit 31.
  - Config bit 30 going 0→1 sets status bit 30.
  - Config bit 30 going 1→0 clears status bit 30.
- R5: Window writes store the written value masked as follows:
  - config: AND 0xFFE00000.
  - refresh: AND 0x3FF80000.
  - power-management: (value AND 0xF8000000) OR 0x07C00000.
  - ECC config: AND 0x00F00000.
  - bank config: AND 0xFFDEE001.
  - ECC error status: AND 0xFFF0F000.
- R6: `ecc_irq` rises in the cycle after a write that takes ECC error status from zero to nonzero. It falls after a write that takes it back to zero.
- R7: `bank_hit[i]` can be 1 only when all of these hold:
  - config bit 31 is 1.
  - bank bit 0 is 1.
  - the bank size code in bits 19:17 is not 7.
  - `lk_addr` lies in [base, base + (4 MiB << code)), where base is bank bits 31:23 followed by 23 zero bits.
- R8: When several banks match, only the lowest-numbered one is reported, so `bank_hit` is one-hot or zero.
- R9: Port offsets other than 0x10 and 0x11 read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_addr | input | 10 | Register-bus port offset |
| reg_wdata | input | 32 | Register-bus write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lk_addr | input | 32 | Address to decode against the banks |
| bank_hit | output | 4 | One-hot bank select for `lk_addr` |
| ecc_irq | output | 1 | High while ECC error status is nonzero |

## Verification
The assertions assume the following about the inputs:
- `reg_wr` is a single-cycle strobe whose address and data are stable around the clock edge.
- `lk_addr` may change freely, because the decode is purely combinational.

The stimulus keeps within these assumptions by driving every bus input on the falling edge and holding each write for exactly one cycle. The assertions also assume that the status word and the interrupt change only as a result of a window write. The bench checks this at the ports by reading back after each write.

// File: rtl/sdram_cfg_pkg.sv
// Shared constants for the indirect SDRAM configuration register file:
// window sub-register offsets, write masks and reset values.
// Assumes a 32-bit data word.
package sdram_cfg_pkg;
    localparam int DW = 32;

    localparam logic [DW-1:0] SUB_BERR0  = 32'h00;
    localparam logic [DW-1:0] SUB_BERR1  = 32'h08;
    localparam logic [DW-1:0] SUB_EADDR  = 32'h10;
    localparam logic [DW-1:0] SUB_CTRL   = 32'h20;
    localparam logic [DW-1:0] SUB_STAT   = 32'h24;
    localparam logic [DW-1:0] SUB_RFSH   = 32'h30;
    localparam logic [DW-1:0] SUB_PWR    = 32'h34;
    localparam logic [DW-1:0] SUB_BANK0  = 32'h40;
    localparam logic [DW-1:0] SUB_BSTEP  = 32'h04;
    localparam logic [DW-1:0] SUB_TIMING = 32'h80;
    localparam logic [DW-1:0] SUB_ECFG   = 32'h94;
    localparam logic [DW-1:0] SUB_ESTAT  = 32'h98;

    localparam logic [DW-1:0] MSK_CTRL   = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR    = 32'hF800_0000;
    localparam logic [DW-1:0] FIX_PWR    = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_ECFG   = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_BANK   = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_ESTAT  = 32'hFFF0_F000;

    localparam logic [DW-1:0] RST_CTRL   = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH   = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR    = 32'h07C0_0000;

    localparam int CTRL_EN_BIT  = 31;
    localparam int CTRL_AUX_BIT = 30;
endpackage

// File: rtl/sdram_cfg_file.sv
// Register file behind the index/data port pair. Holds the index register
// and every sub-register, applies per-register write masks, tracks the
// status bits driven by config transitions, and returns read data
// combinationally. Assumes reg_wr is a one-cycle strobe.
module sdram_cfg_file
    import sdram_cfg_pkg::*;
#(
    parameter int            NUM_BANKS = 4,
    parameter int            PORT_AW   = 10,
    parameter logic [PORT_AW-1:0] IDX_PORT = 'h010,
    parameter logic [PORT_AW-1:0] WIN_PORT = 'h011
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [PORT_AW-1:0]           reg_addr,
    input  logic [DW-1:0]                reg_wdata,
    output logic [DW-1:0]                reg_rdata,
    output logic                         ctrl_en,
    output logic                         ecc_irq,
    output logic [NUM_BANKS-1:0][DW-1:0] bank_cfg
);
    logic [DW-1:0] idx_q, berr0_q, berr1_q, eaddr_q, ctrl_q, stat_q;
    logic [DW-1:0] rfsh_q, pwr_q, ecfg_q, estat_q, win_rd, ctrl_new;
    logic          win_wr, ctrl_wr;

    assign win_wr   = reg_wr && (reg_addr == WIN_PORT);
    assign ctrl_wr  = win_wr && (idx_q == SUB_CTRL);
    assign ctrl_new = reg_wdata & MSK_CTRL;

    // Index register: written whole through the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  idx_q <= '0;
        else if (reg_wr && reg_addr == IDX_PORT)     idx_q <= reg_wdata;
    end

    // Scalar sub-registers: masked stores and write-1-to-clear words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            berr0_q <= '0;       berr1_q <= '0;   eaddr_q <= '0;
            rfsh_q  <= RST_RFSH; pwr_q   <= RST_PWR;
            ecfg_q  <= '0;       estat_q <= '0;
        end else if (win_wr) begin
            case (idx_q)
                SUB_BERR0: berr0_q <= berr0_q & ~reg_wdata;
                SUB_BERR1: berr1_q <= berr1_q & ~reg_wdata;
                SUB_EADDR: eaddr_q <= reg_wdata;
                SUB_RFSH:  rfsh_q  <= reg_wdata & MSK_RFSH;
                SUB_PWR:   pwr_q   <= (reg_wdata & MSK_PWR) | FIX_PWR;
                SUB_ECFG:  ecfg_q  <= reg_wdata & MSK_ECFG;
                SUB_ESTAT: estat_q <= reg_wdata & MSK_ESTAT;
                default: ;
            endcase
        end
    end

    // Config word and the status bits that follow its enable transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RST_CTRL;
            stat_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
            if (!ctrl_q[CTRL_EN_BIT] && ctrl_new[CTRL_EN_BIT])      stat_q[CTRL_EN_BIT] <= 1'b0;
            else if (ctrl_q[CTRL_EN_BIT] && !ctrl_new[CTRL_EN_BIT]) stat_q[CTRL_EN_BIT] <= 1'b1;
            if (!ctrl_q[CTRL_AUX_BIT] && ctrl_new[CTRL_AUX_BIT])      stat_q[CTRL_AUX_BIT] <= 1'b1;
            else if (ctrl_q[CTRL_AUX_BIT] && !ctrl_new[CTRL_AUX_BIT]) stat_q[CTRL_AUX_BIT] <= 1'b0;
        end
    end

    // One masked bank configuration register per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [DW-1:0] OFS = SUB_BANK0 + SUB_BSTEP * b;
        always_ff @(posedge clk) begin
            if (!rst_n)                        bank_cfg[b] <= '0;
            else if (win_wr && idx_q == OFS)   bank_cfg[b] <= reg_wdata & MSK_BANK;
        end
    end

    // Window read mux; unknown offsets and timing read all ones.
    always_comb begin
        case (idx_q)
            SUB_BERR0: win_rd = berr0_q;
            SUB_BERR1: win_rd = berr1_q;
            SUB_EADDR: win_rd = eaddr_q;
            SUB_CTRL:  win_rd = ctrl_q;
            SUB_STAT:  win_rd = stat_q;
            SUB_RFSH:  win_rd = rfsh_q;
            SUB_PWR:   win_rd = pwr_q;
            SUB_ECFG:  win_rd = ecfg_q;
            SUB_ESTAT: win_rd = estat_q;
            default:   win_rd = '1;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx_q == SUB_BANK0 + SUB_BSTEP * b) win_rd = bank_cfg[b];
        end
    end

    // Port-level read select: index, window, or zero elsewhere.
    always_comb begin
        if (reg_addr == IDX_PORT)      reg_rdata = idx_q;
        else if (reg_addr == WIN_PORT) reg_rdata = win_rd;
        else                           reg_rdata = '0;
    end

    assign ctrl_en = ctrl_q[CTRL_EN_BIT];
    assign ecc_irq = |estat_q;

    // R4: status only moves on a config write.
    a_r4_status_moves_on_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(stat_q));
    // R3: bus-error words never gain set bits.
    a_r3_berr_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((berr0_q & ~$past(berr0_q)) == '0) && ((berr1_q & ~$past(berr1_q)) == '0));
    // R6: interrupt edges follow a window write.
    a_r6_irq_edge_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ecc_irq) || $fell(ecc_irq)) |-> $past(win_wr));
    // R9: writes to other port offsets leave the index unchanged.
    a_r9_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == IDX_PORT) |=> $stable(idx_q));
endmodule

// File: rtl/sdram_bank_match.sv
// Range check for one bank: hit when the controller and bank are enabled,
// the size code is legal, and the address is inside [base, base+size).
// Assumes base is aligned to its own width (low bits are zero).
module sdram_bank_match #(
    parameter int AW      = 32,
    parameter int BASE_W  = 9,
    parameter int CODE_W  = 3,
    parameter int UNIT_SH = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              bank_en,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [CODE_W-1:0] size_code,
    input  logic [AW-1:0]     lk_addr,
    output logic              hit
);
    localparam int LOW_W = AW - BASE_W;
    logic [AW:0] base_x, end_x;

    // Base and exclusive end, one bit wider so the end never wraps.
    always_comb begin
        base_x = {1'b0, base_hi, {LOW_W{1'b0}}};
        end_x  = base_x + ((AW + 1)'(1) << (UNIT_SH + int'(size_code)));
    end

    // Hit decision for this bank.
    always_comb begin
        hit = ctrl_en && bank_en && (size_code != '1)
              && ({1'b0, lk_addr} >= base_x) && ({1'b0, lk_addr} < end_x);
    end

    // R7: a hit never reports an address below the bank base.
    a_r7_hit_above_base: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ({1'b0, lk_addr} >= base_x));
endmodule

// File: rtl/sdram_cfg_regs.sv
// Top of the indirect SDRAM configuration register file. Connects the
// register file to one range matcher per bank and keeps only the
// lowest-numbered matching bank. Assumes one register access per cycle.
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PORT_AW   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [PORT_AW-1:0]   reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [DW-1:0]        lk_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 ecc_irq
);
    localparam int BASE_LSB = 23;
    localparam int CODE_LSB = 17;
    localparam int CODE_W   = 3;

    logic                         ctrl_en;
    logic [NUM_BANKS-1:0][DW-1:0] bank_cfg;
    logic [NUM_BANKS-1:0]         raw_hit;

    sdram_cfg_file #(.NUM_BANKS(NUM_BANKS), .PORT_AW(PORT_AW)) u_file (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_en(ctrl_en),
        .ecc_irq(ecc_irq), .bank_cfg(bank_cfg)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        sdram_bank_match #(.AW(DW), .BASE_W(DW - BASE_LSB), .CODE_W(CODE_W)) u_match (
            .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
            .bank_en(bank_cfg[b][0]),
            .base_hi(bank_cfg[b][DW-1:BASE_LSB]),
            .size_code(bank_cfg[b][CODE_LSB+CODE_W-1:CODE_LSB]),
            .lk_addr(lk_addr), .hit(raw_hit[b])
        );
    end

    // Fixed priority: the lowest-numbered matching bank wins.
    always_comb begin
        logic found;
        found    = 1'b0;
        bank_hit = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (raw_hit[b] && !found) begin
                bank_hit[b] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // R8: at most one bank is reported.
    a_r8_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));
    // R7: no bank hits while the controller is disabled.
    a_r7_hit_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit != '0) |-> ctrl_en);
endmodule

// File: tb/tb_sdram_cfg_regs.sv
`timescale 1ns/1ps
module tb_sdram_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_addr = '0;
    logic [3:0]  bank_hit;
    logic        ecc_irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    localparam logic [9:0] P_IDX = 10'h010;
    localparam logic [9:0] P_WIN = 10'h011;

    always #4 clk = ~clk;

    sdram_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    // Row: requirement number, sub-offset, write value, expected read.
    localparam int NV = 10;
    localparam logic [103:0] VEC [0:NV-1] = '{
        {8'd5, 32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},  // R5 refresh mask
        {8'd5, 32'h34, 32'h0000_0000, 32'h07C0_0000},  // R5 power forced bits
        {8'd5, 32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},  // R5 power mask
        {8'd5, 32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},  // R5 ECC config mask
        {8'd2, 32'h80, 32'h0000_0000, 32'hFFFF_FFFF},  // R2 timing reads ones
        {8'd2, 32'h10, 32'h1234_5678, 32'h1234_5678},  // R2 error address
        {8'd4, 32'h24, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 status read-only
        {8'd2, 32'h04, 32'hAAAA_5555, 32'hFFFF_FFFF},  // R2 unknown offset
        {8'd5, 32'h4C, 32'hFFFF_FFFF, 32'hFFDE_E001},  // R5 bank mask
        {8'd3, 32'h00, 32'hFFFF_FFFF, 32'h0000_0000}   // R3 W1C stays clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic pwr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic prd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic sub_wr(input logic [31:0] ofs, input logic [31:0] d);
        pwr(P_IDX, ofs);
        pwr(P_WIN, d);
    endtask

    task automatic sub_rd(input logic [31:0] ofs, output logic [31:0] d);
        pwr(P_IDX, ofs);
        prd(P_WIN, d);
    endtask

    task automatic hit_chk(input string req, input logic [31:0] a, input logic [3:0] exp);
        lk_addr = a;
        #1;
        chk(req, {28'h0, bank_hit}, {28'h0, exp});
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        prd(P_IDX, r);                  chk("R1 index", r, 32'h0);
        chk("R1 irq", {31'h0, ecc_irq}, 32'h0);
        chk("R1 hit", {28'h0, bank_hit}, 32'h0);
        sub_rd(32'h20, r);              chk("R1 config", r, 32'h0080_0000);
        sub_rd(32'h30, r);              chk("R1 refresh", r, 32'h05F0_0000);
        sub_rd(32'h34, r);              chk("R1 power", r, 32'h07C0_0000);
        sub_rd(32'h98, r);              chk("R1 ecc status", r, 32'h0);
        sub_rd(32'h40, r);              chk("R1 bank0", r, 32'h0);

        // Table walk of masks and read rules
        for (int i = 0; i < NV; i++) begin
            sub_wr(VEC[i][95:64], VEC[i][63:32]);
            prd(P_WIN, r);
            chk($sformatf("R%0d row %0d", VEC[i][103:96], i), r, VEC[i][31:0]);
        end

        // R4 status transitions on config writes
        sub_wr(32'h20, 32'hFFFF_FFFF);
        prd(P_WIN, r);                  chk("R5 config mask", r, 32'hFFE0_0000);
        sub_rd(32'h24, r);              chk("R4 enable+aux set", r, 32'h4000_0000);
        sub_wr(32'h20, 32'h0);
        sub_rd(32'h24, r);              chk("R4 disable", r, 32'h8000_0000);
        sub_wr(32'h20, 32'h8000_0000);
        sub_rd(32'h24, r);              chk("R4 re-enable", r, 32'h0);

        // R7 and R8 bank decode
        sub_wr(32'h40, 32'h0000_0001);  // base 0, 4 MiB
        sub_wr(32'h44, 32'h0004_0001);  // base 0, 16 MiB, overlaps bank0
        sub_wr(32'h48, 32'h100C_0001);  // base 256 MiB, 256 MiB
        sub_wr(32'h4C, 32'h400E_0001);  // size code 7, never hits
        hit_chk("R8 overlap low", 32'h0010_0000, 4'b0001);
        hit_chk("R8 bank0 top", 32'h003F_FFFF, 4'b0001);
        hit_chk("R7 bank1 only", 32'h0040_0000, 4'b0010);
        hit_chk("R7 bank1 top", 32'h00FF_FFFF, 4'b0010);
        hit_chk("R7 gap", 32'h0100_0000, 4'b0000);
        hit_chk("R7 bank2 base", 32'h1000_0000, 4'b0100);
        hit_chk("R7 bank2 top", 32'h1FFF_FFFF, 4'b0100);
        hit_chk("R7 bank2 end", 32'h2000_0000, 4'b0000);
        hit_chk("R7 code7", 32'h4000_0000, 4'b0000);
        sub_wr(32'h48, 32'h100C_0000);
        hit_chk("R7 bank disabled", 32'h1000_0000, 4'b0000);
        sub_wr(32'h20, 32'h0);
        hit_chk("R7 ctrl disabled", 32'h0010_0000, 4'b0000);

        // R6 ECC interrupt
        sub_wr(32'h98, 32'h000F_0FFF);
        chk("R6 masked zero irq", {31'h0, ecc_irq}, 32'h0);
        prd(P_WIN, r);                  chk("R5 ecc status mask", r, 32'h0);
        sub_wr(32'h98, 32'h0000_1000);
        chk("R6 irq rise", {31'h0, ecc_irq}, 32'h1);
        sub_wr(32'h98, 32'h0);
        chk("R6 irq fall", {31'h0, ecc_irq}, 32'h0);

        // R9 other port offsets
        pwr(P_IDX, 32'h30);
        pwr(10'h012, 32'h0000_0020);
        prd(10'h012, r);                chk("R9 other port reads 0", r, 32'h0);
        prd(P_IDX, r);                  chk("R9 index kept", r, 32'h30);
        prd(P_WIN, r);                  chk("R9 refresh kept", r, 32'h3FF8_0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule